// File: doc/BRIEF.md
# Serial Register Port

This block is the slave end of a serial link that moves whole bytes between a host and a byte-wide register file. A decoder elsewhere starts each transfer with a one-cycle pulse that gives the direction, the first byte address and the length. The block then counts serial clock edges. It assembles incoming bits into bytes and issues one write strobe per finished byte. For reads it places the addressed bytes on the line bit by bit.

The serial clock is oversampled by the system clock. Data is taken on a rising serial clock edge, and outgoing data changes after a falling edge. A 16-bit control word lives inside the block at two byte addresses. Three of its bits choose the address direction, the bit order inside a byte, and whether read data shares the bidirectional data pin or leaves on a dedicated output. A transfer may rewrite those bits, and the new setting governs the rest of that same transfer.

Top module: `srp_port`

## Requirements
- R1: After reset the control word reads 0 (descending addresses, MSB first, two-wire), no write strobe is issued, the shared pin is not driven and the dedicated output is 0.
- R2: In a write transfer, each group of 8 rising serial clock edges forms one byte; with control bit 1 = 0 the first bit taken is bit 7. For an external address, a single-cycle `reg_wr_en` pulse presents that byte on `reg_wdata` with its address on `reg_addr`.
- R3: With control bit 1 = 1 the bit order inside each byte is reversed (bit 0 travels first), for both written and read bytes.
- R4: With control bit 2 = 0 the byte address decreases by one after each byte, modulo 2^AW.
- R5: With control bit 2 = 1 the byte address increases by one after each byte, modulo 2^AW, wrapping from the top address to 0.
- R6: In a read transfer the byte at the current address is sent in the selected bit order, the first bit before the first rising edge and each later bit after a falling edge. With control bit 0 = 0 it appears on `sdio_out` with `sdio_oe` high and `sdo` held at 0. With control bit 0 = 1 it appears on `sdo` and `sdio_oe` stays low.
- R7: `sdio_oe` is high only while a read transfer is active, and it is low during writes and once the last byte has been clocked.
- R8: Byte address CR_LO (default 0) holds control bits 7..0 and CR_HI (default 1) holds bits 15..8. Accesses to them stay inside the block and raise no `reg_wr_en`. Bits 15..13 always read 0.
- R9: A control-word byte written during a transfer takes effect from the following address step onward, for the rest of the same transfer.
- R10: A start pulse that arrives while a transfer is active is ignored.
- R11: A length value n on `start_len` moves exactly n+1 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a transfer |
| start_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| start_addr | input | AW | First byte address |
| start_len | input | LW | Number of bytes minus one |
| sclk | input | 1 | Serial clock, idles low |
| sdio_in | input | 1 | Input side of the shared data pin |
| sdio_out | output | 1 | Output side of the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo | output | 1 | Dedicated serial data output |
| reg_addr | output | AW | Current byte address |
| reg_wr_en | output | 1 | Write strobe toward the register file |
| reg_wdata | output | 8 | Byte to be written |
| reg_rdata | input | 8 | Register file byte at `reg_addr` |
| cfg_word | output | 16 | Stored control word |

## Verification
All eight combinations of the three mode bits are swept. In each, three bytes are written and read back with values that differ per byte and per mode, so a bit-order slip, a wrong step direction or a mixed-up pin shows as a distinct mismatch. A transfer that starts at the top address and runs through the two control-word bytes separates address wrap, internal register handling and reserved-bit masking from external strobes. A transfer that reverses the address direction partway through shows whether the step after that byte uses the new setting. A start pulse issued mid-transfer must leave the running write untouched.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 3;
  localparam int CFG_W    = 16;
  localparam int BIT_ASC  = 2;   // address direction select
  localparam int BIT_LSBF = 1;   // bit order select
  localparam int BIT_3W   = 0;   // dedicated output select
  localparam int RSV_HI   = 15;
  localparam int RSV_LO   = 13;

  // Bit of a byte that travels in slot idx of the serial stream.
  function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                    input logic [IDX_W-1:0]  idx,
                                    input logic              lsb_first);
    return lsb_first ? b[idx] : b[IDX_W'(BYTE_W-1) - idx];
  endfunction
endpackage

// File: rtl/srp_edge_det.sv
module srp_edge_det #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic din,
  output logic rise,
  output logic fall,
  output logic din_s
);
  logic [SYNC:0] clk_sh;
  logic [SYNC:0] dat_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh <= '0;
      dat_sh <= '0;
    end else begin
      clk_sh <= {clk_sh[SYNC-1:0], sclk};
      dat_sh <= {dat_sh[SYNC-1:0], din};
    end
  end

  assign rise  =  clk_sh[SYNC-1] & ~clk_sh[SYNC];
  assign fall  = ~clk_sh[SYNC-1] &  clk_sh[SYNC];
  assign din_s =  dat_sh[SYNC-1];
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              fall,
  input  logic              reload,
  input  logic              din,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] wbyte,
  output logic              out_bit
);
  logic [IDX_W-1:0]  bit_q, bit_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              ob_q, ob_n;

  assign wbyte     = lsb_first ? {din, sh_q[BYTE_W-1:1]} : {sh_q[BYTE_W-2:0], din};
  assign byte_done = rise & (bit_q == IDX_W'(BYTE_W-1));
  assign out_bit   = ob_q;

  always_comb begin
    bit_n = bit_q;
    sh_n  = sh_q;
    ob_n  = ob_q;
    if (clr) begin
      bit_n = '0;
    end else if (rise) begin
      bit_n = bit_q + 1'b1;
      sh_n  = wbyte;
    end
    if (reload || fall) begin
      ob_n = pick_bit(rd_byte, bit_q, lsb_first);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      sh_q  <= '0;
      ob_q  <= 1'b0;
    end else begin
      bit_q <= bit_n;
      sh_q  <= sh_n;
      ob_q  <= ob_n;
    end
  end
endmodule

// File: rtl/srp_ctrl_reg.sv
module srp_ctrl_reg
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CFG_W-1:0]  cr
);
  logic [CFG_W-1:0] cr_q, cr_n;

  always_comb begin
    cr_n = cr_q;
    if (we_lo) cr_n[BYTE_W-1:0]     = wdata;
    if (we_hi) cr_n[CFG_W-1:BYTE_W] = wdata;
    cr_n[RSV_HI:RSV_LO] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_q <= '0;
    else        cr_q <= cr_n;
  end

  assign cr = cr_q;
endmodule

// File: rtl/srp_port.sv
module srp_port
  import srp_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LW    = 3,
  parameter int SYNC  = 2,
  parameter int CR_LO = 0,
  parameter int CR_HI = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [AW-1:0]     start_addr,
  input  logic [LW-1:0]     start_len,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo,
  output logic [AW-1:0]     reg_addr,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [CFG_W-1:0]  cfg_word
);
  localparam logic [AW-1:0] A_LO = AW'(CR_LO);
  localparam logic [AW-1:0] A_HI = AW'(CR_HI);

  logic              s_rise, s_fall, s_din;
  logic              byte_done, out_bit;
  logic [BYTE_W-1:0] wbyte, rd_byte;
  logic [CFG_W-1:0]  cr;

  logic              busy_q, busy_n, rd_q, rd_n, step_q, step_n;
  logic              reload_q, reload_n, wr_q, wr_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic [LW-1:0]     cnt_q, cnt_n;
  logic [BYTE_W-1:0] wd_q, wd_n;
  logic              accept, hit_lo, hit_hi, is_wr_done;

  srp_edge_det #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(sdio_in),
    .rise(s_rise), .fall(s_fall), .din_s(s_din)
  );

  assign accept     = start & ~busy_q;
  assign hit_lo     = (addr_q == A_LO);
  assign hit_hi     = (addr_q == A_HI);
  assign is_wr_done = busy_q & ~rd_q & byte_done;
  assign rd_byte    = hit_lo ? cr[BYTE_W-1:0] : hit_hi ? cr[CFG_W-1:BYTE_W] : reg_rdata;

  srp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .rise(s_rise & busy_q), .fall(s_fall & busy_q), .reload(reload_q),
    .din(s_din), .lsb_first(cr[BIT_LSBF]), .rd_byte(rd_byte),
    .byte_done(byte_done), .wbyte(wbyte), .out_bit(out_bit)
  );

  srp_ctrl_reg u_cr (
    .clk(clk), .rst_n(rst_n),
    .we_lo(is_wr_done & hit_lo), .we_hi(is_wr_done & hit_hi),
    .wdata(wbyte), .cr(cr)
  );

  always_comb begin
    busy_n   = busy_q;
    rd_n     = rd_q;
    addr_n   = addr_q;
    cnt_n    = cnt_q;
    wd_n     = wd_q;
    step_n   = 1'b0;
    reload_n = 1'b0;
    wr_n     = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_n   = 1'b1;
        rd_n     = start_rd;
        addr_n   = start_addr;
        cnt_n    = start_len;
        reload_n = start_rd;
      end
    end else if (step_q) begin
      addr_n = cr[BIT_ASC] ? addr_q + 1'b1 : addr_q - 1'b1;
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end else if (byte_done) begin
      step_n = 1'b1;
      if (!rd_q && !hit_lo && !hit_hi) begin
        wr_n = 1'b1;
        wd_n = wbyte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      wd_q     <= '0;
      step_q   <= 1'b0;
      reload_q <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      busy_q   <= busy_n;
      rd_q     <= rd_n;
      addr_q   <= addr_n;
      cnt_q    <= cnt_n;
      wd_q     <= wd_n;
      step_q   <= step_n;
      reload_q <= reload_n;
      wr_q     <= wr_n;
    end
  end

  assign sdio_out  = out_bit;
  assign sdio_oe   = busy_q & rd_q & ~cr[BIT_3W];
  assign sdo       = busy_q & rd_q & cr[BIT_3W] & out_bit;
  assign reg_addr  = addr_q;
  assign reg_wr_en = wr_q;
  assign reg_wdata = wd_q;
  assign cfg_word  = cr;
endmodule

// File: rtl/srp_port_chk.sv
module srp_port_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdio_oe,
  input logic          sdo,
  input logic [15:0]   cfg_word,
  input logic          reg_wr_en,
  input logic [AW-1:0] reg_addr,
  input logic          busy
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[15:13] == 3'b000); // R8
  AST_OE_TWO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !cfg_word[0]); // R6
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[0] |-> !sdo); // R6
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_addr == ($past(cfg_word[2]) ? AW'($past(reg_addr) + 1'b1)
                                                  : AW'($past(reg_addr) - 1'b1))); // R4
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdio_oe); // R7
endmodule

bind srp_port srp_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdio_oe(sdio_oe), .sdo(sdo),
  .cfg_word(cfg_word), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .busy(busy_q)
);

// File: tb/srp_port_test.sv
module srp_port_test;
  localparam int AW = 4;
  localparam int LW = 3;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_rd = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic sclk = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, reg_wr_en;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [15:0] cfg_word;

  logic [7:0] mem [16];
  logic [AW-1:0] lg_addr [64];
  logic [7:0] lg_data [64];
  int n_st = 0;
  int errors = 0, checks = 0;
  logic m_asc = 0, m_lsb = 0, m_3w = 0;

  always #10 clk = ~clk;

  srp_port #(.AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .start_addr(start_addr), .start_len(start_len), .sclk(sclk),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cfg_word(cfg_word)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
      if (n_st < 64) begin
        lg_addr[n_st] <= reg_addr;
        lg_data[n_st] <= reg_wdata;
      end
      n_st <= n_st + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer(input logic rd, input logic [AW-1:0] a, input logic [LW-1:0] len);
    @(negedge clk);
    start = 1'b1; start_rd = rd; start_addr = a; start_len = len;
    tick(1);
    start = 1'b0;
    tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sdio_in = m_lsb ? b[i] : b[7-i];
      sclk = 1'b1; tick(H);
      sclk = 1'b0; tick(H);
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (m_lsb) b[i] = m_3w ? sdo : sdio_out;
      else       b[7-i] = m_3w ? sdo : sdio_out;
      if (i == 0) chk(sdio_oe == !m_3w, "R6 oe during read", int'(sdio_oe), int'(!m_3w));
      sclk = 1'b1; tick(H);
      sclk = 1'b0; tick(H);
    end
  endtask

  function automatic logic [7:0] pat(input int c, input int k);
    return 8'(8'h5A ^ (c * 37 + k * 91));
  endfunction

  task automatic set_cfg(input logic [7:0] v);
    begin_xfer(1'b0, 4'd0, 3'd0);
    send_byte(v);
    tick(4);
    m_asc = v[2]; m_lsb = v[1]; m_3w = v[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int base;
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17);
    tick(3);
    // R1 reset state
    chk(cfg_word == 16'h0, "R1 cfg", cfg_word, 0);
    chk(!sdio_oe, "R1 oe", sdio_oe, 0);
    chk(!reg_wr_en, "R1 strobe", reg_wr_en, 0);
    chk(!sdo, "R1 sdo", sdo, 0);
    rst_n = 1'b1;
    tick(3);

    // Sweep all mode combinations: R2 R3 R4 R5 R6 R7 R11
    for (int c = 0; c < 8; c++) begin
      set_cfg(8'(c));
      chk(cfg_word[2:0] == 3'(c), "R8 cfg lo stored", cfg_word[2:0], c);
      base = n_st;
      begin_xfer(1'b0, 4'd8, 3'd2);
      chk(!sdio_oe, "R7 oe low during write", sdio_oe, 0);
      for (int k = 0; k < 3; k++) send_byte(pat(c, k));
      tick(4);
      chk(n_st == base + 3, "R11 strobe count", n_st - base, 3);
      for (int k = 0; k < 3; k++) begin
        logic [AW-1:0] ea;
        ea = m_asc ? AW'(8 + k) : AW'(8 - k);
        chk(lg_addr[base+k] == ea, m_asc ? "R5 ascending addr" : "R4 descending addr",
            lg_addr[base+k], ea);
        chk(lg_data[base+k] == pat(c, k), m_lsb ? "R3 lsb-first write" : "R2 msb-first write",
            lg_data[base+k], pat(c, k));
      end
      begin_xfer(1'b1, 4'd8, 3'd2);
      for (int k = 0; k < 3; k++) begin
        recv_byte(got);
        chk(got == pat(c, k), m_3w ? "R6 read on sdo" : "R6 read on shared pin", got, pat(c, k));
      end
      tick(4);
      chk(!sdio_oe, "R7 oe low after read", sdio_oe, 0);
      chk(!sdo, "R7 sdo idle after read", sdo, 0);
    end

    // Wrap through control word: R5 R8 (mode 7 active)
    base = n_st;
    begin_xfer(1'b0, 4'd15, 3'd2);
    send_byte(8'hC3);
    send_byte(8'h07);
    send_byte(8'hFF);
    tick(4);
    chk(n_st == base + 1, "R8 no strobe for control bytes", n_st - base, 1);
    chk(lg_addr[base] == 4'd15 && lg_data[base] == 8'hC3, "R5 top address write",
        lg_addr[base], 15);
    chk(cfg_word == 16'h1F07, "R8 reserved bits masked", cfg_word, 16'h1F07);
    begin_xfer(1'b1, 4'd0, 3'd1);
    recv_byte(got);
    chk(got == 8'h07, "R8 read cfg lo", got, 8'h07);
    recv_byte(got);
    chk(got == 8'h1F, "R8 read cfg hi", got, 8'h1F);
    tick(4);

    // Mid-transfer direction change: R9
    set_cfg(8'h00);
    base = n_st;
    begin_xfer(1'b0, 4'd0, 3'd1);
    send_byte(8'h04);
    m_asc = 1'b1;
    send_byte(8'hF3);
    tick(4);
    chk(n_st == base, "R9 no external strobe", n_st - base, 0);
    chk(mem[15] == 8'hC3, "R9 top address untouched", mem[15], 8'hC3);
    chk(cfg_word == 16'h1304, "R9 new direction used", cfg_word, 16'h1304);

    // Start while busy: R10
    base = n_st;
    begin_xfer(1'b0, 4'd4, 3'd0);
    @(negedge clk);
    start = 1'b1; start_rd = 1'b1; start_addr = 4'd9; start_len = 3'd5;
    tick(1);
    start = 1'b0;
    send_byte(8'h96);
    tick(4);
    chk(n_st == base + 1, "R10 single strobe", n_st - base, 1);
    chk(lg_addr[base] == 4'd4 && lg_data[base] == 8'h96, "R10 original transfer kept",
        lg_data[base], 8'h96);
    chk(!sdio_oe, "R10 no read started", sdio_oe, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule